// File: doc/BRIEF.md
# Soft-Start Staircase and Hiccup Sequencer

This block sequences the digital reference code that feeds the error amplifier's reference DAC of a switching regulator. Once enabled, it climbs the code from zero to full scale in equal staircase steps. Each step lasts a fixed number of switching-clock ticks, so the whole climb takes `STEPS * TICKS_PER_STEP` ticks (2048 with the defaults). When the code reaches its top value the regulator is declared in regulation.

If an overcurrent is flagged while in regulation, the sequencer makes a hiccup. It inhibits the power stage, forces the code to zero and waits one full ramp duration counted in ticks. It then starts a new ramp from zero. An overcurrent flagged during the ramp does not start a hiccup. It is handed on through a registered output to the pulse-skipping logic.

A thermal-fault flag, already hysteretic, inhibits the power stage while it is high. Its release starts a fresh ramp. Removing enable returns the sequencer to idle at once.

Top module: `ssramp_seq`

## Requirements
- R1: While `rst` is high, and on the first cycle after it, the outputs are `ref_code_o`=0, `ss_active_o`=0, `in_reg_o`=0, `inhibit_o`=1 and `ocp_skip_o`=0.
- R2: With `en_i` high and `therm_i` low in idle, on the next clock `ss_active_o`=1, `inhibit_o`=0 and `ref_code_o`=0.
- R3: During the ramp `ref_code_o` rises by exactly one after every 32nd sampled `tick_i`, counted from ramp start. It is constant between those ticks and never exceeds 64.
- R4: On the clock that samples the 2048th tick of a ramp, `ref_code_o` becomes 64, `in_reg_o` becomes 1 and `ss_active_o` becomes 0. The code then holds at 64.
- R5: `ocp_i` high during regulation causes, on the next clock, `ref_code_o`=0, `inhibit_o`=1 and `in_reg_o`=0.
- R6: The hiccup hold lasts exactly 2048 ticks. On the clock that samples the 2048th tick, a ramp starts from code 0 with its step counter cleared.
- R7: `ocp_i` during the ramp leaves the ramp running. `ocp_skip_o` equals the previous cycle's `ocp_i` while the new state is ramping, and is 0 otherwise.
- R8: `therm_i` high with `en_i` high gives, on the next clock, `inhibit_o`=1, `ref_code_o`=0 and both status flags 0. Ticks are ignored while `therm_i` stays high.
- R9: Releasing `therm_i` with `en_i` high starts a fresh ramp from code 0 on the next clock.
- R10: `en_i` low returns all outputs to their idle values on the next clock, from any state. A later enable ramps again from code 0 with a cleared step counter.
- R11: `ss_active_o` and `in_reg_o` are never high together. `inhibit_o` is high exactly when neither of them is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | One-cycle pulse per switching period |
| en_i | input | 1 | Sequencer enable |
| ocp_i | input | 1 | Overcurrent flag from the current sensor |
| therm_i | input | 1 | Hysteretic over-temperature flag |
| ref_code_o | output | CODE_W (7) | Reference code for the DAC |
| ss_active_o | output | 1 | Ramp in progress |
| in_reg_o | output | 1 | Full-scale code reached |
| inhibit_o | output | 1 | Power stage must stay off |
| ocp_skip_o | output | 1 | Overcurrent passed to pulse skipping during the ramp |

## Verification
Every output is a register loaded from the next state, so each result is due on the first clock edge that samples its stimulus. For a tick, that edge is the one that sees `tick_i` high. For an enable, fault or overcurrent change, it is the edge after the change. The bench drives inputs on the falling edge and compares outputs on the following falling edge, one full register stage later. Tick counts are tallied by the bench, so the code expected at each boundary (31, 32, 2047 and 2048 ticks) follows from the step arithmetic alone.

// File: rtl/ssq_pkg.sv
package ssq_pkg;
  typedef enum logic [2:0] {
    SQ_IDLE   = 3'd0,
    SQ_RAMP   = 3'd1,
    SQ_REG    = 3'd2,
    SQ_HICCUP = 3'd3,
    SQ_THERM  = 3'd4
  } sq_state_t;
endpackage

// File: rtl/ssq_tick_timer.sv
module ssq_tick_timer #(
  parameter int TICKS_PER_STEP = 32
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic run,
  input  logic tick,
  output logic step_done
);
  localparam int SUB_W = (TICKS_PER_STEP > 1) ? $clog2(TICKS_PER_STEP) : 1;
  localparam logic [SUB_W-1:0] SUB_LAST = SUB_W'(TICKS_PER_STEP - 1);

  logic [SUB_W-1:0] sub_q;

  assign step_done = run && tick && (sub_q == SUB_LAST);

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      sub_q <= '0;
    end else if (run && tick) begin
      if (step_done) sub_q <= '0;
      else           sub_q <= sub_q + 1'b1;
    end
  end
endmodule

// File: rtl/ssq_step_code.sv
module ssq_step_code #(
  parameter int STEPS  = 64,
  parameter int CODE_W = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              step_done,
  input  logic              show_ramp,
  input  logic              show_full,
  output logic              wrap_o,
  output logic [CODE_W-1:0] code_o
);
  localparam logic [CODE_W-1:0] FULL     = CODE_W'(STEPS);
  localparam logic [CODE_W-1:0] PRE_FULL = CODE_W'(STEPS - 1);

  logic [CODE_W-1:0] step_q;
  logic [CODE_W-1:0] step_next;

  assign wrap_o = step_done && (step_q == PRE_FULL);

  always_comb begin
    if (clr)            step_next = '0;
    else if (step_done) step_next = step_q + 1'b1;
    else                step_next = step_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      step_q <= '0;
      code_o <= '0;
    end else begin
      step_q <= step_next;
      if (show_full)      code_o <= FULL;
      else if (show_ramp) code_o <= step_next;
      else                code_o <= '0;
    end
  end
endmodule

// File: rtl/ssq_ctrl.sv
module ssq_ctrl
  import ssq_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic en_i,
  input  logic therm_i,
  input  logic ocp_i,
  input  logic wrap,
  output logic run,
  output logic clr,
  output logic show_ramp,
  output logic show_full,
  output logic ss_active_o,
  output logic in_reg_o,
  output logic inhibit_o,
  output logic ocp_skip_o
);
  sq_state_t state_q, state_d;

  always_comb begin
    state_d = state_q;
    if (!en_i) begin
      state_d = SQ_IDLE;
    end else if (therm_i) begin
      state_d = SQ_THERM;
    end else begin
      case (state_q)
        SQ_IDLE:   state_d = SQ_RAMP;
        SQ_THERM:  state_d = SQ_RAMP;
        SQ_RAMP:   if (wrap) state_d = SQ_REG;
        SQ_REG:    if (ocp_i) state_d = SQ_HICCUP;
        SQ_HICCUP: if (wrap) state_d = SQ_RAMP;
        default:   state_d = SQ_IDLE;
      endcase
    end
  end

  assign run       = (state_q == SQ_RAMP) || (state_q == SQ_HICCUP);
  assign clr       = (state_d != state_q);
  assign show_ramp = (state_d == SQ_RAMP);
  assign show_full = (state_d == SQ_REG);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= SQ_IDLE;
      ss_active_o <= 1'b0;
      in_reg_o    <= 1'b0;
      inhibit_o   <= 1'b1;
      ocp_skip_o  <= 1'b0;
    end else begin
      state_q     <= state_d;
      ss_active_o <= (state_d == SQ_RAMP);
      in_reg_o    <= (state_d == SQ_REG);
      inhibit_o   <= !((state_d == SQ_RAMP) || (state_d == SQ_REG));
      ocp_skip_o  <= (state_d == SQ_RAMP) && ocp_i;
    end
  end
endmodule

// File: rtl/ssramp_seq.sv
module ssramp_seq #(
  parameter int STEPS          = 64,
  parameter int TICKS_PER_STEP = 32,
  parameter int CODE_W         = $clog2(STEPS + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick_i,
  input  logic              en_i,
  input  logic              ocp_i,
  input  logic              therm_i,
  output logic [CODE_W-1:0] ref_code_o,
  output logic              ss_active_o,
  output logic              in_reg_o,
  output logic              inhibit_o,
  output logic              ocp_skip_o
);
  logic run, clr, step_done, wrap, show_ramp, show_full;

  ssq_ctrl ctrl_i (
    .clk        (clk),
    .rst        (rst),
    .en_i       (en_i),
    .therm_i    (therm_i),
    .ocp_i      (ocp_i),
    .wrap       (wrap),
    .run        (run),
    .clr        (clr),
    .show_ramp  (show_ramp),
    .show_full  (show_full),
    .ss_active_o(ss_active_o),
    .in_reg_o   (in_reg_o),
    .inhibit_o  (inhibit_o),
    .ocp_skip_o (ocp_skip_o)
  );

  ssq_tick_timer #(.TICKS_PER_STEP(TICKS_PER_STEP)) timer_i (
    .clk      (clk),
    .rst      (rst),
    .clr      (clr),
    .run      (run),
    .tick     (tick_i),
    .step_done(step_done)
  );

  ssq_step_code #(.STEPS(STEPS), .CODE_W(CODE_W)) code_i (
    .clk      (clk),
    .rst      (rst),
    .clr      (clr),
    .step_done(step_done),
    .show_ramp(show_ramp),
    .show_full(show_full),
    .wrap_o   (wrap),
    .code_o   (ref_code_o)
  );
endmodule

// File: rtl/ssramp_seq_chk.sv
module ssramp_seq_chk #(
  parameter int STEPS  = 64,
  parameter int CODE_W = 7
) (
  input logic              clk,
  input logic              rst,
  input logic              en_i,
  input logic              ocp_i,
  input logic              therm_i,
  input logic [CODE_W-1:0] ref_code_o,
  input logic              ss_active_o,
  input logic              in_reg_o,
  input logic              inhibit_o,
  input logic              ocp_skip_o
);
  localparam logic [CODE_W-1:0] FULL = CODE_W'(STEPS);

  p_start_zero_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(ss_active_o) |-> ref_code_o == '0);

  p_code_max_r3: assert property (@(posedge clk) disable iff (rst)
    ref_code_o <= FULL);

  p_code_step_r3: assert property (@(posedge clk) disable iff (rst)
    (ss_active_o && $past(ss_active_o)) |->
      (ref_code_o == $past(ref_code_o) || ref_code_o == $past(ref_code_o) + 1'b1));

  p_reg_full_r4: assert property (@(posedge clk) disable iff (rst)
    in_reg_o |-> ref_code_o == FULL);

  p_hiccup_r5: assert property (@(posedge clk) disable iff (rst)
    (in_reg_o && ocp_i && en_i && !therm_i) |=> (inhibit_o && ref_code_o == '0 && !in_reg_o));

  p_skip_r7: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (ocp_skip_o == ($past(ocp_i) && ss_active_o)));

  p_therm_r8: assert property (@(posedge clk) disable iff (rst)
    (en_i && therm_i) |=> (inhibit_o && ref_code_o == '0 && !ss_active_o && !in_reg_o));

  p_en_off_r10: assert property (@(posedge clk) disable iff (rst)
    !en_i |=> (inhibit_o && ref_code_o == '0 && !ss_active_o && !in_reg_o && !ocp_skip_o));

  p_flags_r11: assert property (@(posedge clk) disable iff (rst)
    $onehot0({ss_active_o, in_reg_o}) && (inhibit_o == !(ss_active_o || in_reg_o)));
endmodule

bind ssramp_seq ssramp_seq_chk #(.STEPS(STEPS), .CODE_W(CODE_W)) chk_i (
  .clk        (clk),
  .rst        (rst),
  .en_i       (en_i),
  .ocp_i      (ocp_i),
  .therm_i    (therm_i),
  .ref_code_o (ref_code_o),
  .ss_active_o(ss_active_o),
  .in_reg_o   (in_reg_o),
  .inhibit_o  (inhibit_o),
  .ocp_skip_o (ocp_skip_o)
);

// File: tb/ssramp_seq_tb_top.sv
module ssramp_seq_tb_top;
  localparam int STEPS = 64;
  localparam int TPS   = 32;
  localparam int RAMP  = STEPS * TPS;
  localparam int CW    = $clog2(STEPS + 1);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tick_i = 1'b0, en_i = 1'b0, ocp_i = 1'b0, therm_i = 1'b0;
  logic [CW-1:0] ref_code_o;
  logic ss_active_o, in_reg_o, inhibit_o, ocp_skip_o;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  ssramp_seq #(.STEPS(STEPS), .TICKS_PER_STEP(TPS)) dut_i (
    .clk(clk), .rst(rst), .tick_i(tick_i), .en_i(en_i), .ocp_i(ocp_i),
    .therm_i(therm_i), .ref_code_o(ref_code_o), .ss_active_o(ss_active_o),
    .in_reg_o(in_reg_o), .inhibit_o(inhibit_o), .ocp_skip_o(ocp_skip_o)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic chk_out(input string req, input int code, input int ss, input int rg, input int inh);
    chk(req, "ref_code_o", int'(ref_code_o), code);
    chk(req, "ss_active_o", int'(ss_active_o), ss);
    chk(req, "in_reg_o", int'(in_reg_o), rg);
    chk(req, "inhibit_o", int'(inhibit_o), inh);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) tick_i = 1'b1;
      @(negedge clk) tick_i = 1'b0;
    end
  endtask

  task automatic ocp_pulse();
    @(negedge clk) ocp_i = 1'b1;
    @(negedge clk) ocp_i = 1'b0;
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    chk_out("R1", 0, 0, 0, 1);
    chk("R1", "ocp_skip_o", int'(ocp_skip_o), 0);
    @(negedge clk) rst = 1'b0;
    @(negedge clk);
    chk_out("R1", 0, 0, 0, 1);
  endtask

  task automatic t_ramp();
    @(negedge clk) en_i = 1'b1;
    @(negedge clk);
    chk_out("R2", 0, 1, 0, 0);
    ticks(TPS - 1);
    chk("R3", "code after 31 ticks", int'(ref_code_o), 0);
    ticks(1);
    chk("R3", "code after 32 ticks", int'(ref_code_o), 1);
    ticks(RAMP - 1 - TPS);
    chk_out("R4", STEPS - 1, 1, 0, 0);
    ticks(1);
    chk_out("R4", STEPS, 0, 1, 0);
    ticks(100);
    chk_out("R3", STEPS, 0, 1, 0);
    chk("R11", "flags exclusive", int'(ss_active_o & in_reg_o), 0);
  endtask

  task automatic t_hiccup();
    ocp_pulse();
    chk_out("R5", 0, 0, 0, 1);
    ticks(RAMP - 1);
    chk_out("R6", 0, 0, 0, 1);
    ticks(1);
    chk_out("R6", 0, 1, 0, 0);
    ticks(TPS - 1);
    chk("R6", "code after 31 restart ticks", int'(ref_code_o), 0);
    ticks(1);
    chk("R6", "code after 32 restart ticks", int'(ref_code_o), 1);
  endtask

  task automatic t_ramp_ocp();
    ocp_pulse();
    chk("R7", "ocp_skip_o", int'(ocp_skip_o), 1);
    chk_out("R7", 1, 1, 0, 0);
    @(negedge clk);
    chk("R7", "ocp_skip_o after", int'(ocp_skip_o), 0);
    ticks(RAMP - TPS);
    chk_out("R7", STEPS, 0, 1, 0);
    chk("R11", "inhibit in regulation", int'(inhibit_o), 0);
  endtask

  task automatic t_therm();
    @(negedge clk) therm_i = 1'b1;
    @(negedge clk);
    chk_out("R8", 0, 0, 0, 1);
    ticks(100);
    chk_out("R8", 0, 0, 0, 1);
    ocp_pulse();
    chk("R8", "ocp_skip_o while hot", int'(ocp_skip_o), 0);
    @(negedge clk) therm_i = 1'b0;
    @(negedge clk);
    chk_out("R9", 0, 1, 0, 0);
    ticks(TPS);
    chk("R9", "code after 32 ticks", int'(ref_code_o), 1);
  endtask

  task automatic t_enable();
    ticks(10);
    @(negedge clk) en_i = 1'b0;
    @(negedge clk);
    chk_out("R10", 0, 0, 0, 1);
    ocp_pulse();
    ticks(40);
    chk_out("R10", 0, 0, 0, 1);
    chk("R10", "ocp_skip_o idle", int'(ocp_skip_o), 0);
    @(negedge clk) en_i = 1'b1;
    @(negedge clk);
    chk_out("R10", 0, 1, 0, 0);
    ticks(TPS - 1);
    chk("R10", "code after 31 ticks", int'(ref_code_o), 0);
    ticks(1);
    chk("R10", "code after 32 ticks", int'(ref_code_o), 1);
  endtask

  task automatic t_hot_start();
    @(negedge clk) en_i = 1'b0;
    therm_i = 1'b1;
    @(negedge clk);
    chk_out("R10", 0, 0, 0, 1);
    @(negedge clk) en_i = 1'b1;
    @(negedge clk);
    chk_out("R8", 0, 0, 0, 1);
    @(negedge clk) en_i = 1'b0;
    @(negedge clk) therm_i = 1'b0;
    @(negedge clk);
    chk_out("R10", 0, 0, 0, 1);
  endtask

  initial begin
    t_reset();
    t_ramp();
    t_hiccup();
    t_ramp_ocp();
    t_therm();
    t_enable();
    t_hot_start();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule